// File: doc/BRIEF.md
# Raw Pixel Shift-and-Pack Formatter

This block sits between a raw sensor pixel stream and a memory writer. It takes 12-bit raw pixels, one per handshake, and drops a chosen number of low bits from each one. It then packs the results into 32-bit words, one word per output handshake. The memory writer stores those words as they arrive. Three storage layouts are available. In the first, each pixel sits in its own 16-bit half of the word. In the second, four 8-bit pixels share a word. In the third, eight 12-bit pixels are spread across three words, and some pixels cross a word boundary.

The pixel that carries the start-of-line marker samples the shift and layout settings. Those settings then hold for every pixel of that line. The pixel that carries the end-of-line marker closes the line. Any partly filled word goes out with its empty bit positions cleared, and the next line starts again at the first slot of a word. If the output is stalled, the input is stalled too, so no pixel is ever lost.

Top module: `raw_pixel_packer`

## Requirements
- R1: For shift codes 0 to 4 on `cfg_shift`, each pixel is shifted right by that many bits before it is stored, and zeros fill the vacated upper bits.
- R2: Shift codes 5, 6 and 7 each act as a right shift of 4.
- R3: Layout code 0 (halfword): each pixel fills bits [11:0] of a 16-bit half and bits [15:12] are zero. The first pixel of a pair goes in word bits [15:0] and the second in [31:16].
- R4: Layout code 1 (byte): four pixels per word. Pixel k of the group is stored in bits [8k+7:8k], and only the low 8 bits of the shifted pixel are kept.
- R5: Layout code 2 (12-bit): eight pixels fill three words as one continuous little-endian bit stream, with pixel k at stream bits [12k+11:12k]. So word 0 holds P0, P1 and P2[7:0]. Word 1 holds P2[11:8], P3, P4 and P5[3:0]. Word 2 holds P5[11:4], P6 and P7.
- R6: The layout and shift are taken from `cfg_mode` and `cfg_shift` on the accepted pixel that has `in_sol` set. Changes to those inputs later in the line have no effect on that line.
- R7: When the end-of-line pixel leaves a word partly filled, that word is emitted with its unused bits at zero and `out_eol` set. The next line begins at slot 0 of a fresh word.
- R8: In 12-bit layout, an end-of-line pixel in group position 2 or 5 completes one word and leaves carried bits. The block emits two words: the completed word with `out_eol` clear, then a word holding only the carried bits with `out_eol` set. No input is accepted between the two.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_word` and `out_eol` hold their values.
- R10: Layout code 3 behaves exactly like layout code 0.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift | input | 3 | Right-shift code, sampled on the start-of-line pixel |
| cfg_mode | input | 2 | Layout code (0 halfword, 1 byte, 2 12-bit, 3 as 0), sampled on the start-of-line pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pixel | input | 12 | Raw pixel value |
| in_sol | input | 1 | This pixel is the first of a line |
| in_eol | input | 1 | This pixel is the last of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_word | output | 32 | Packed memory word |
| out_eol | output | 1 | This word is the last word of a line |

## Verification
The assertions check the handshake rules on every cycle. A stalled word must stay stable, and the input must be blocked both while the output is stalled and while a carried end-of-line word is waiting. In halfword layout they also check that the top nibble of each half is zero, and that a latched shift of four or more clears the upper byte of each half. The bench scenarios are the only way to show the exact bit positions in each layout. They also show that start-of-line sampling ignores changes made mid-line, that partial words are flushed, and that the two-word end of a line falls out as expected in 12-bit layout. The bench compares whole lines against a bit-stream model that is built without reference to the design.

// File: rtl/raw_pack_pkg.sv
// Package: raw_pack_pkg
// Shared widths and the layout encoding for the raw pixel packer.
// Assumes a 12-bit pixel and a 32-bit memory word. The 12-bit slot map in
// raw_pack_lane is written for exactly these widths.
package raw_pack_pkg;

    localparam int PIX_W     = 12;
    localparam int WORD_W    = 32;
    localparam int SHIFT_W   = 3;
    localparam int MAX_SHIFT = 4;
    localparam int PHASE_W   = 3;

    typedef enum logic [1:0] {
        PK_HALF   = 2'd0,
        PK_BYTE   = 2'd1,
        PK_TRIPLE = 2'd2,
        PK_RSVD   = 2'd3
    } pack_mode_e;

    // Fold the reserved code onto the halfword layout.
    function automatic pack_mode_e norm_mode(input logic [1:0] code);
        pack_mode_e m;
        case (code)
            2'd1:    m = PK_BYTE;
            2'd2:    m = PK_TRIPLE;
            default: m = PK_HALF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/raw_pack_shift.sv
// Module: raw_pack_shift
// Combinational right shifter for one pixel. Codes above MAX_SHIFT saturate
// to MAX_SHIFT. Zeros enter from the top.
// Assumes MAX_SHIFT < PIX_W and that MAX_SHIFT fits in SHIFT_W bits.
module raw_pack_shift #(
    parameter int PIX_W     = 12,
    parameter int SHIFT_W   = 3,
    parameter int MAX_SHIFT = 4
) (
    input  logic [PIX_W-1:0]   pix_in,
    input  logic [SHIFT_W-1:0] code,
    output logic [PIX_W-1:0]   pix_out
);

    localparam int NCAND = MAX_SHIFT + 1;

    logic [PIX_W-1:0] cand [NCAND];

    // One candidate per legal shift amount.
    for (genvar s = 0; s < NCAND; s++) begin : g_cand
        assign cand[s] = pix_in >> s;
    end

    // Pick the candidate; any code beyond the limit uses the largest shift.
    always_comb begin
        pix_out = cand[MAX_SHIFT];
        for (int s = 0; s < NCAND; s++) begin
            if (int'(code) == s) pix_out = cand[s];
        end
    end

endmodule

// File: rtl/raw_pack_lane.sv
// Module: raw_pack_lane
// Places one shifted pixel into the word being built, given the layout and
// the slot position (phase) within the current group. It reports whether
// the word is now complete and which bits carry into the next word.
// Assumes PIX_W = 12 and WORD_W = 32 (fixed slot map for the 12-bit layout).
module raw_pack_lane
    import raw_pack_pkg::*;
(
    input  pack_mode_e          mode,
    input  logic [PHASE_W-1:0]  phase,
    input  logic [WORD_W-1:0]   acc,
    input  logic [PIX_W-1:0]    pix,
    output logic [WORD_W-1:0]   merged,
    output logic                complete,
    output logic [WORD_W-1:0]   carry,
    output logic                has_carry,
    output logic [PHASE_W-1:0]  phase_next
);

    logic [WORD_W-1:0] place_half;
    logic [WORD_W-1:0] place_byte;
    logic [WORD_W-1:0] place_tri;
    logic [WORD_W-1:0] carry_tri;

    // Halfword slot: zero-extended pixel in the low or high half.
    always_comb begin
        if (phase[0]) place_half = {4'b0, pix, 16'b0};
        else          place_half = {20'b0, pix};
    end

    // Byte slot: low 8 bits of the pixel in one of four lanes.
    always_comb begin
        case (phase[1:0])
            2'd0:    place_byte = {24'b0, pix[7:0]};
            2'd1:    place_byte = {16'b0, pix[7:0], 8'b0};
            2'd2:    place_byte = {8'b0, pix[7:0], 16'b0};
            default: place_byte = {pix[7:0], 24'b0};
        endcase
    end

    // 12-bit slot map: eight pixels over three words, two of them split.
    always_comb begin
        carry_tri = '0;
        case (phase)
            3'd0: place_tri = {20'b0, pix};
            3'd1: place_tri = {8'b0, pix, 12'b0};
            3'd2: begin
                place_tri = {pix[7:0], 24'b0};
                carry_tri = {28'b0, pix[11:8]};
            end
            3'd3: place_tri = {16'b0, pix, 4'b0};
            3'd4: place_tri = {4'b0, pix, 16'b0};
            3'd5: begin
                place_tri = {pix[3:0], 28'b0};
                carry_tri = {24'b0, pix[11:4]};
            end
            3'd6: place_tri = {12'b0, pix, 8'b0};
            default: place_tri = {pix, 20'b0};
        endcase
    end

    // Select the layout and derive completion, carry and the next slot.
    always_comb begin
        carry     = '0;
        has_carry = 1'b0;
        case (mode)
            PK_BYTE: begin
                merged     = acc | place_byte;
                complete   = (phase[1:0] == 2'd3);
                phase_next = {1'b0, phase[1:0] + 2'd1};
            end
            PK_TRIPLE: begin
                merged     = acc | place_tri;
                complete   = (phase == 3'd2) || (phase == 3'd5) || (phase == 3'd7);
                carry      = carry_tri;
                has_carry  = (phase == 3'd2) || (phase == 3'd5);
                phase_next = phase + 3'd1;
            end
            default: begin
                merged     = acc | place_half;
                complete   = phase[0];
                phase_next = {2'b0, ~phase[0]};
            end
        endcase
    end

endmodule

// File: rtl/raw_pixel_packer.sv
// Module: raw_pixel_packer
// Top of the raw pixel shift-and-pack formatter. It latches the layout and
// shift on each start-of-line pixel, shifts and places each pixel, and
// drives one registered output word with a valid/ready handshake. At end of
// line it flushes a partial word, and when needed it sends a second word
// holding bits carried across the word boundary.
// Assumes every line ends with an in_eol pixel before the next in_sol pixel.
module raw_pixel_packer
    import raw_pack_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_shift,
    input  logic [1:0]          cfg_mode,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [11:0]         in_pixel,
    input  logic                in_sol,
    input  logic                in_eol,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [31:0]         out_word,
    output logic                out_eol
);

    pack_mode_e           line_mode;
    logic [SHIFT_W-1:0]   line_shift;
    pack_mode_e           eff_mode;
    logic [SHIFT_W-1:0]   eff_shift;
    logic [PIX_W-1:0]     pix_sh;
    logic [WORD_W-1:0]    acc;
    logic [PHASE_W-1:0]   phase;
    logic                 pend;
    logic [WORD_W-1:0]    merged;
    logic                 complete;
    logic [WORD_W-1:0]    carry;
    logic                 has_carry;
    logic [PHASE_W-1:0]   phase_next;
    logic                 out_free;
    logic                 fire;
    logic                 load;
    logic [WORD_W-1:0]    load_word;
    logic                 load_eol;
    logic                 out_valid_q;
    logic [WORD_W-1:0]    out_word_q;
    logic                 out_eol_q;

    // Handshake terms: the output slot is free or draining this cycle.
    assign out_free = !out_valid_q || out_ready;
    assign in_ready = out_free && !pend;
    assign fire     = in_valid && in_ready;

    // The start-of-line pixel uses the live settings; the rest use the latch.
    assign eff_mode  = in_sol ? norm_mode(cfg_mode) : line_mode;
    assign eff_shift = in_sol ? cfg_shift : line_shift;

    raw_pack_shift #(
        .PIX_W     (PIX_W),
        .SHIFT_W   (SHIFT_W),
        .MAX_SHIFT (MAX_SHIFT)
    ) u_shift (
        .pix_in  (in_pixel),
        .code    (eff_shift),
        .pix_out (pix_sh)
    );

    raw_pack_lane u_lane (
        .mode       (eff_mode),
        .phase      (phase),
        .acc        (acc),
        .pix        (pix_sh),
        .merged     (merged),
        .complete   (complete),
        .carry      (carry),
        .has_carry  (has_carry),
        .phase_next (phase_next)
    );

    // Latch the line settings on the accepted start-of-line pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_mode  <= PK_HALF;
            line_shift <= '0;
        end else if (fire && in_sol) begin
            line_mode  <= eff_mode;
            line_shift <= cfg_shift;
        end
    end

    // Decide what, if anything, enters the output register this cycle.
    always_comb begin
        load      = 1'b0;
        load_word = merged;
        load_eol  = 1'b0;
        if (pend && out_free) begin
            load      = 1'b1;
            load_word = acc;
            load_eol  = 1'b1;
        end else if (fire) begin
            if (complete) begin
                load     = 1'b1;
                load_eol = in_eol && !has_carry;
            end else if (in_eol) begin
                load     = 1'b1;
                load_eol = 1'b1;
            end
        end
    end

    // Keep the partial word, the group slot and the carried-word flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            phase <= '0;
            pend  <= 1'b0;
        end else if (pend && out_free) begin
            acc  <= '0;
            pend <= 1'b0;
        end else if (fire) begin
            phase <= in_eol ? '0 : phase_next;
            pend  <= in_eol && complete && has_carry;
            if (in_eol && !(complete && has_carry)) acc <= '0;
            else if (complete)                      acc <= carry;
            else                                    acc <= merged;
        end
    end

    // Output word register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_word_q  <= '0;
            out_eol_q   <= 1'b0;
        end else if (load) begin
            out_valid_q <= 1'b1;
            out_word_q  <= load_word;
            out_eol_q   <= load_eol;
        end else if (out_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    assign out_valid = out_valid_q;
    assign out_word  = out_word_q;
    assign out_eol   = out_eol_q;

endmodule

// File: rtl/raw_pixel_packer_chk.sv
// Module: raw_pixel_packer_chk
// Protocol and layout checker, attached to raw_pixel_packer by bind.
// Assumes it observes the top ports and the latched line settings.
module raw_pixel_packer_chk
    import raw_pack_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_word,
    input logic        out_eol,
    input logic        pend,
    input pack_mode_e  line_mode,
    input logic [2:0]  line_shift
);

    // R9: a stalled word stays put.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_eol));

    // R9: a stalled output blocks the input.
    assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R8: no pixel is taken while a carried end-of-line word waits.
    assert_carry_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !in_ready);

    // R8: the carried word is the last of its line.
    assert_carry_eol_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend && (!out_valid || out_ready) |=> out_valid && out_eol);

    // R3: in halfword layout the top nibble of each half is zero.
    assert_half_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && line_mode == PK_HALF |-> out_word[15:12] == 4'h0 && out_word[31:28] == 4'h0);

    // R1 and R2: a shift of four or more clears the upper byte of each half.
    assert_shift_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && line_mode == PK_HALF && line_shift >= 3'd4
        |-> out_word[15:8] == 8'h0 && out_word[31:24] == 8'h0);

endmodule

bind raw_pixel_packer raw_pixel_packer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .out_eol    (out_eol),
    .pend       (pend),
    .line_mode  (line_mode),
    .line_shift (line_shift)
);

// File: tb/raw_pixel_packer_bench.sv
// Directed bench for raw_pixel_packer. Each task drives one scenario and
// checks its words against a bit-stream model of the layout.
module raw_pixel_packer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_shift = '0;
    logic [1:0]  cfg_mode = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_pixel = '0;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;
    logic        out_eol;

    int nchk = 0;
    int nfail = 0;
    logic [11:0] px [32];
    logic [31:0] got_w [16];
    logic        got_e [16];
    int          ncol = 0;
    bit          drv_done = 1'b0;

    always #2 clk = ~clk;

    raw_pixel_packer u_raw_pixel_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_shift (cfg_shift),
        .cfg_mode  (cfg_mode),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pixel  (in_pixel),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .out_eol   (out_eol)
    );

    // Record each output handshake, sampled half a cycle before its edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && ncol < 16) begin
            got_w[ncol] = out_word;
            got_e[ncol] = out_eol;
            ncol = ncol + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int slot_w(input int md);
        if (md == 1) return 8;
        if (md == 2) return 12;
        return 16;
    endfunction

    // Model: pixel i occupies stream bits [i*W +: W]; words are 32-bit chunks.
    function automatic logic [31:0] model_word(input int k, input int n, input int md, input int sh);
        logic [31:0] w = '0;
        int W = slot_w(md);
        int amt = (sh > 4) ? 4 : sh;
        for (int b = 0; b < 32; b++) begin
            int g = k * 32 + b;
            int idx = g / W;
            int bit_i = g % W;
            logic [11:0] sp;
            if (idx < n && bit_i < 12) begin
                sp = px[idx] >> amt;
                w[b] = sp[bit_i];
            end
        end
        return w;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 32; i++) px[i] = 12'((seed * 37 + i * 421 + i * i * 13) & 12'hFFF);
    endtask

    // Send one line; optionally disturb the settings after the first pixel.
    task automatic send_line(input int n, input int md, input int sh, input bit disturb);
        cfg_mode  = 2'(md);
        cfg_shift = 3'(sh);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_pixel = px[i];
            in_sol   = (i == 0);
            in_eol   = (i == n - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
            if (disturb && i == 0) begin
                cfg_mode  = ~cfg_mode;
                cfg_shift = 3'd4;
            end
        end
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eol   = 1'b0;
        drv_done = 1'b1;
    endtask

    task automatic idle(input int c);
        repeat (c) @(posedge clk);
        #1;
    endtask

    task automatic check_line(input int n, input int md, input int sh, input string req);
        int nw = (n * slot_w(md) + 31) / 32;
        chk(ncol == nw, {req, " word count"}, 32'(ncol), 32'(nw));
        for (int k = 0; k < nw && k < ncol; k++) begin
            chk(got_w[k] == model_word(k, n, md, sh), {req, " word"}, got_w[k], model_word(k, n, md, sh));
            chk(got_e[k] == (k == nw - 1), {req, " eol flag"}, 32'(got_e[k]), 32'(k == nw - 1));
        end
    endtask

    task automatic run_line(input int n, input int md, input int sh, input int seed, input string req);
        fill(seed);
        ncol = 0;
        send_line(n, md, sh, 1'b0);
        idle(8);
        check_line(n, md, sh, req);
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 1);
    endtask

    task automatic t_half;
        run_line(4, 0, 0, 3, "R3 halfword layout");
        run_line(5, 0, 0, 5, "R7 halfword partial flush");
    endtask

    task automatic t_shift;
        for (int s = 0; s < 8; s++) begin
            fill(11 + s);
            px[0] = 12'hFFF;
            px[1] = 12'hA5C;
            ncol = 0;
            send_line(2, 0, s, 1'b0);
            idle(6);
            if (s < 5) check_line(2, 0, s, "R1 shift code");
            else       check_line(2, 0, s, "R2 saturated shift code");
        end
    endtask

    task automatic t_byte;
        run_line(8, 1, 0, 7, "R4 byte layout");
        run_line(7, 1, 2, 9, "R4 R7 byte layout shifted partial");
    endtask

    task automatic t_triple;
        run_line(8, 2, 0, 13, "R5 12-bit layout");
        run_line(16, 2, 1, 15, "R5 12-bit two groups");
        run_line(3, 2, 0, 17, "R8 carry after P2");
        run_line(6, 2, 0, 19, "R8 carry after P5");
        run_line(5, 2, 0, 21, "R7 12-bit partial");
    endtask

    task automatic t_rsvd;
        run_line(3, 3, 1, 23, "R10 reserved layout");
        // Same pixels under layout 0 give the same words.
        chk(got_w[0] == model_word(0, 3, 0, 1), "R10 matches halfword", got_w[0], model_word(0, 3, 0, 1));
    endtask

    task automatic t_sample;
        fill(25);
        ncol = 0;
        send_line(6, 1, 1, 1'b1);
        idle(8);
        check_line(6, 1, 1, "R6 settings held for line");
        cfg_mode = 2'd0;
        cfg_shift = 3'd0;
    endtask

    task automatic t_stall;
        logic [31:0] w0;
        fill(27);
        ncol = 0;
        out_ready = 1'b0;
        drv_done = 1'b0;
        fork
            send_line(4, 0, 0, 1'b0);
        join_none
        idle(10);
        @(negedge clk);
        w0 = out_word;
        chk(out_valid == 1'b1, "R9 word waiting", 32'(out_valid), 1);
        chk(in_ready == 1'b0, "R9 input blocked", 32'(in_ready), 0);
        chk(w0 == model_word(0, 4, 0, 0), "R9 held word", w0, model_word(0, 4, 0, 0));
        idle(3);
        @(negedge clk);
        chk(out_word == w0, "R9 word stable", out_word, w0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        wait (drv_done);
        idle(8);
        check_line(4, 0, 0, "R9 stalled line complete");
    endtask

    initial begin
        #(200000 * 4);
        nfail++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_half();
        t_shift();
        t_byte();
        t_triple();
        t_rsvd();
        t_sample();
        t_stall();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule